// File: doc/BRIEF.md
# Predicate Mask Lookup Unit

This unit sits beside operand decode and answers one question per query: for an integer or floating-point destination register, which element mask applies? A small table of configuration entries, loaded through a CSR-style write port, binds a key register (plus an int/fp selector) to a predicate source held in an integer register. When a query hits, the unit issues a read to the integer register file, inverts the returned word if the entry says so, and hands back the mask with the zeroing flag. When nothing is bound to the queried register, every element is active and the mask is all ones.

The entries are expanded into two per-register views, one for integer and one for floating-point keys, so a query is a single indexed select rather than a search at decode time. When several entries bind the same key, the entry at the highest index wins. The register-file read has one cycle of latency, and each query yields exactly one result, flagged by a valid strobe two cycles after the query. Queries may issue on back-to-back cycles.

Top module: `pred_mask_lookup`

## Requirements
- R1: After reset the result strobe is low, no register read is issued, and no entry is bound, so any query returns an all-ones mask.
- R2: A configuration word uses this layout: bit 13 bank, bit 12 zeroing, bit 11 invert, bit 10 key class (0 integer, 1 floating-point), bits 9..5 key register, bits 4..0 predicate register; writing it to an entry index binds that entry.
- R3: A query whose register and class match no bound entry issues no register read and returns predication-off, zeroing low and an all-ones mask.
- R4: A query that hits reads the integer register file in the same cycle at the 6-bit address {bank, predicate register}, and reports predication-on.
- R5: With invert set the returned mask is the bitwise complement of the read word; with invert clear it is the read word unchanged.
- R6: The zeroing bit of the hitting entry is returned with the mask; it is low whenever predication is off.
- R7: Integer and floating-point keys are separate: an entry bound to one class never answers a query of the other class for the same register number.
- R8: When several bound entries share a key and class, the one with the highest index supplies the result.
- R9: Each query produces exactly one result with the strobe high two cycles after the query cycle; back-to-back queries produce back-to-back results in order.
- R10: A configuration write is visible to queries from the next cycle on, and rewriting an entry with a new key removes its old binding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 4 | Entry index to write |
| cfg_wdata | input | 14 | Configuration word |
| q_valid | input | 1 | Query present this cycle |
| q_is_fp | input | 1 | Query class: 1 floating-point, 0 integer |
| q_reg | input | 5 | Queried destination register |
| rf_re | output | 1 | Integer register-file read request |
| rf_raddr | output | 6 | Read address {bank, register} |
| rf_rdata | input | XLEN | Read data, one cycle after rf_re |
| r_valid | output | 1 | Result strobe |
| r_pred_en | output | 1 | Predication applies |
| r_zero | output | 1 | Zeroing mode for masked-off elements |
| r_mask | output | XLEN | Element mask |

## Verification
The bench targets entry shadowing: a lower-index entry written after a higher one must not take over, and rewriting the winner to a different key must uncover the older binding, which a first-match or stale-table design would get wrong. It checks that a floating-point binding does not answer an integer query of the same number, which a design that drops the class bit from the key would fail, and that the bank bit reaches the read address. Inversion and the all-ones miss result are checked against complemented and raw register contents, catching a design that inverts on a miss or returns the raw word. A long pipelined random run with writes interleaved against queries catches off-by-one latency and a write made visible in the wrong cycle.

// File: rtl/pml_pkg.sv
package pml_pkg;

    localparam int KEY_W  = 5;
    localparam int CFG_W  = 14;
    localparam int ADDR_W = KEY_W + 1;

    // configuration entry, MSB first: bank, zero, inv, class, key, pidx
    typedef struct packed {
        logic             bank;
        logic             zero;
        logic             inv;
        logic             is_fp;
        logic [KEY_W-1:0] key;
        logic [KEY_W-1:0] pidx;
    } entry_t;

    // one slot of the expanded per-register view
    typedef struct packed {
        logic             hit;
        logic             bank;
        logic             zero;
        logic             inv;
        logic [KEY_W-1:0] pidx;
    } slot_t;

endpackage

// File: rtl/pml_entry_store.sv
module pml_entry_store
    import pml_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [CFG_W-1:0] cfg_wdata,
    output entry_t           ent   [NUM_ENTRIES],
    output logic [NUM_ENTRIES-1:0] ent_vld
);

    typedef struct packed {
        entry_t [NUM_ENTRIES-1:0] ent;
        logic   [NUM_ENTRIES-1:0] vld;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.ent[cfg_idx] = entry_t'(cfg_wdata);
            st_d.vld[cfg_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_out
        assign ent[e] = st_q.ent[e];
    end
    assign ent_vld = st_q.vld;

    // R10: a written entry is bound from the next cycle
    p_write_binds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ent_vld[$past(cfg_idx)]);

    // R1: nothing bound until a write arrives
    p_vld_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $countones(ent_vld) == $countones($past(ent_vld)));

endmodule

// File: rtl/pml_expand.sv
module pml_expand
    import pml_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int NUM_REGS = 1 << KEY_W
) (
    input  entry_t                 ent [NUM_ENTRIES],
    input  logic [NUM_ENTRIES-1:0] ent_vld,
    output slot_t                  tbl [2*NUM_REGS]
);

    // slot index is {class, register}; later entries overwrite earlier ones
    for (genvar c = 0; c < 2; c++) begin : g_class
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            always_comb begin
                tbl[c*NUM_REGS + r] = '0;
                for (int e = 0; e < NUM_ENTRIES; e++) begin
                    if (ent_vld[e] && (ent[e].is_fp == c[0]) &&
                        (ent[e].key == KEY_W'(r))) begin
                        tbl[c*NUM_REGS + r].hit  = 1'b1;
                        tbl[c*NUM_REGS + r].bank = ent[e].bank;
                        tbl[c*NUM_REGS + r].zero = ent[e].zero;
                        tbl[c*NUM_REGS + r].inv  = ent[e].inv;
                        tbl[c*NUM_REGS + r].pidx = ent[e].pidx;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pml_mask_stage.sv
module pml_mask_stage #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            q_valid,
    input  logic            s_hit,
    input  logic            s_inv,
    input  logic            s_zero,
    input  logic [XLEN-1:0] rf_rdata,
    output logic            r_valid,
    output logic            r_pred_en,
    output logic            r_zero,
    output logic [XLEN-1:0] r_mask
);

    typedef struct packed {
        logic            s1_v;
        logic            s1_hit;
        logic            s1_inv;
        logic            s1_zero;
        logic            r_v;
        logic            r_pen;
        logic            r_zero;
        logic [XLEN-1:0] r_mask;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.s1_v    = q_valid;
        st_d.s1_hit  = q_valid & s_hit;
        st_d.s1_inv  = s_inv;
        st_d.s1_zero = s_zero;
        st_d.r_v     = st_q.s1_v;
        st_d.r_pen   = st_q.s1_hit;
        st_d.r_zero  = st_q.s1_hit & st_q.s1_zero;
        if (!st_q.s1_hit)     st_d.r_mask = '1;
        else if (st_q.s1_inv) st_d.r_mask = ~rf_rdata;
        else                  st_d.r_mask = rf_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign r_valid   = st_q.r_v;
    assign r_pred_en = st_q.r_pen;
    assign r_zero    = st_q.r_zero;
    assign r_mask    = st_q.r_mask;

    // R9: a query yields a result two cycles later
    p_query_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1_v |=> r_valid);

    // R3: miss result is all ones
    p_miss_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid && !r_pred_en |-> &r_mask);

    // R5: inverted hit complements the word read in the previous cycle
    p_inv_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1_v && st_q.s1_hit && st_q.s1_inv |=> r_mask == ~$past(rf_rdata));

    // R6: zeroing only reported with predication on
    p_zero_needs_pred_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_zero |-> r_pred_en);

endmodule

// File: rtl/pred_mask_lookup.sv
module pred_mask_lookup
    import pml_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W    = $clog2(NUM_ENTRIES),
    localparam int NUM_REGS = 1 << KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              q_valid,
    input  logic              q_is_fp,
    input  logic [KEY_W-1:0]  q_reg,
    output logic              rf_re,
    output logic [ADDR_W-1:0] rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              r_valid,
    output logic              r_pred_en,
    output logic              r_zero,
    output logic [XLEN-1:0]   r_mask
);

    entry_t                 ent [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] ent_vld;
    slot_t                  tbl [2*NUM_REGS];
    slot_t                  sel;

    pml_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .ent       (ent),
        .ent_vld   (ent_vld)
    );

    pml_expand #(.NUM_ENTRIES(NUM_ENTRIES)) u_expand (
        .ent     (ent),
        .ent_vld (ent_vld),
        .tbl     (tbl)
    );

    assign sel      = tbl[{q_is_fp, q_reg}];
    assign rf_re    = q_valid & sel.hit;
    assign rf_raddr = {sel.bank, sel.pidx};

    pml_mask_stage #(.XLEN(XLEN)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_valid   (q_valid),
        .s_hit     (sel.hit),
        .s_inv     (sel.inv),
        .s_zero    (sel.zero),
        .rf_rdata  (rf_rdata),
        .r_valid   (r_valid),
        .r_pred_en (r_pred_en),
        .r_zero    (r_zero),
        .r_mask    (r_mask)
    );

    // R3: reads only on behalf of a query
    p_read_needs_query_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |-> q_valid);

    // R4: a read request leads to predication-on two edges later
    p_read_gives_pred_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |=> ##1 (r_valid && r_pred_en));

    // R9: no result without a query two cycles before
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> ##1 !r_valid);

endmodule

// File: tb/tb_pred_mask_lookup.sv
`timescale 1ns/1ps
module tb_pred_mask_lookup;

    localparam int XLEN = 64;

    typedef struct packed {
        logic            v;
        logic            pen;
        logic            zero;
        logic            rd;
        logic [5:0]      addr;
        logic [XLEN-1:0] mask;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [3:0]      cfg_idx = '0;
    logic [13:0]     cfg_wdata = '0;
    logic            q_valid = 1'b0;
    logic            q_is_fp = 1'b0;
    logic [4:0]      q_reg = '0;
    logic            rf_re;
    logic [5:0]      rf_raddr;
    logic [XLEN-1:0] rf_rdata = '0;
    logic            r_valid, r_pred_en, r_zero;
    logic [XLEN-1:0] r_mask;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [XLEN-1:0] regs [64];
    logic [13:0]     m_ent [16];
    logic [15:0]     m_vld = '0;

    always #2.5 clk = ~clk;

    pred_mask_lookup #(.XLEN(XLEN), .NUM_ENTRIES(16)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .q_valid(q_valid), .q_is_fp(q_is_fp),
        .q_reg(q_reg), .rf_re(rf_re), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .r_valid(r_valid), .r_pred_en(r_pred_en), .r_zero(r_zero), .r_mask(r_mask)
    );

    // register file model, one cycle read latency
    always @(posedge clk) if (rf_re) rf_rdata <= regs[rf_raddr];

    task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] mk(input bit bank, input bit zero, input bit inv,
                                       input bit fp, input int key, input int pidx);
        return {bank, zero, inv, fp, key[4:0], pidx[4:0]};
    endfunction

    // reference: highest bound index matching class and key wins
    function automatic exp_t ref_q(input bit fp, input logic [4:0] r);
        exp_t x;
        x = '0;
        x.v = 1'b1;
        x.mask = '1;
        for (int e = 0; e < 16; e++) begin
            if (m_vld[e] && m_ent[e][10] == fp && m_ent[e][9:5] == r) begin
                x.pen  = 1'b1;
                x.rd   = 1'b1;
                x.zero = m_ent[e][12];
                x.addr = {m_ent[e][13], m_ent[e][4:0]};
                x.mask = m_ent[e][11] ? ~regs[x.addr] : regs[x.addr];
            end
        end
        return x;
    endfunction

    task automatic wr(input int idx, input logic [13:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx[3:0]; cfg_wdata = w;
        m_ent[idx] = w; m_vld[idx] = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic query(input bit fp, input int r, input string req);
        exp_t x;
        x = ref_q(fp, r[4:0]);
        q_valid = 1'b1; q_is_fp = fp; q_reg = r[4:0];
        #1;
        chk(rf_re == x.rd, {req, " read"}, XLEN'(rf_re), XLEN'(x.rd));
        if (x.rd) chk(rf_raddr == x.addr, {req, " addr"}, XLEN'(rf_raddr), XLEN'(x.addr));
        @(negedge clk);
        q_valid = 1'b0;
        chk(r_valid == 1'b0, {req, " R9 early"}, XLEN'(r_valid), 0);
        @(negedge clk);
        chk(r_valid == 1'b1, {req, " R9 valid"}, XLEN'(r_valid), 1);
        chk(r_pred_en == x.pen, {req, " pen"}, XLEN'(r_pred_en), XLEN'(x.pen));
        chk(r_zero == x.zero, {req, " zero"}, XLEN'(r_zero), XLEN'(x.zero));
        chk(r_mask == x.mask, {req, " mask"}, r_mask, x.mask);
    endtask

    initial begin
        exp_t e0, e1, nx;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 64; i++) regs[i] = {$urandom, $urandom};
        for (int i = 0; i < 16; i++) m_ent[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(r_valid == 1'b0, "R1 strobe", XLEN'(r_valid), 0);
        chk(rf_re == 1'b0, "R1 read", XLEN'(rf_re), 0);
        query(0, 3, "R1 R3 empty int");
        query(1, 0, "R1 R3 empty fp");

        // R2 R4 R6: plain binding, zeroing on
        wr(2, mk(0, 1, 0, 0, 7, 9));
        query(0, 7, "R2 R4 R6 int7");
        // R7: same number, other class
        query(1, 7, "R7 fp7 miss");
        // R5: inverted fp binding
        wr(5, mk(0, 0, 1, 1, 7, 4));
        query(1, 7, "R5 R7 fp7 inv");
        query(0, 7, "R7 int7 unchanged");
        // R8: higher index overrides, lower index written later does not
        wr(9, mk(0, 0, 0, 0, 7, 12));
        query(0, 7, "R8 int7 from entry9");
        wr(1, mk(0, 1, 1, 0, 7, 20));
        query(0, 7, "R8 int7 still entry9");
        // R4: bank bit becomes address MSB
        wr(3, mk(1, 0, 0, 0, 11, 2));
        query(0, 11, "R4 bank addr");
        // R10: rekeying entry 9 uncovers entry 2
        wr(9, mk(0, 0, 0, 0, 8, 12));
        query(0, 7, "R10 R8 int7 uncovered");
        query(0, 8, "R10 int8 new key");

        // R9 R10: pipelined random run with interleaved writes
        e0 = '0; e1 = '0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (e1.v) begin
                chk(r_valid, "R9 burst valid", XLEN'(r_valid), 1);
                chk(r_pred_en == e1.pen, "R9 burst pen", XLEN'(r_pred_en), XLEN'(e1.pen));
                chk(r_zero == e1.zero, "R6 burst zero", XLEN'(r_zero), XLEN'(e1.zero));
                chk(r_mask == e1.mask, "R5 R8 burst mask", r_mask, e1.mask);
            end else begin
                chk(!r_valid, "R9 burst idle", XLEN'(r_valid), 0);
            end
            e1 = e0;
            nx = '0;
            q_valid = ($urandom % 4) != 0;
            q_is_fp = $urandom % 2;
            q_reg = 5'($urandom % 8);
            if (q_valid) nx = ref_q(q_is_fp, q_reg);
            e0 = nx;
            // write applies to the model after the lookup of this cycle
            cfg_we = ($urandom % 4) == 0;
            if (cfg_we) begin
                cfg_idx = 4'($urandom);
                cfg_wdata = mk(($urandom % 8) == 0, $urandom % 2, $urandom % 2,
                               $urandom % 2, $urandom % 8, $urandom % 32);
                m_ent[cfg_idx] = cfg_wdata;
                m_vld[cfg_idx] = 1'b1;
            end
            #1;
            chk(rf_re == nx.rd, "R4 R10 burst read", XLEN'(rf_re), XLEN'(nx.rd));
            if (nx.rd) chk(rf_raddr == nx.addr, "R4 burst addr", XLEN'(rf_raddr), XLEN'(nx.addr));
        end
        @(negedge clk);
        q_valid = 1'b0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        chk(!r_valid, "R9 drained", XLEN'(r_valid), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule